// File: doc/BRIEF.md
# Logical Block Allocation Tracker

This block records, for a single storage namespace, which logical blocks have been written at least once. It holds one bit per block in on-chip storage, packed into 32-bit words. The bitmap starts all zero and returns to zero after a format request. A block's bit is set only when the data path reports that a write or write-zeroes to that block has completed successfully.

Read commands arrive on the command port and can be checked against the bitmap. The check runs only when the namespace's error-recovery word has its enable bit set. When it runs, the block scans the requested range one word per clock and returns a dedicated error status if any block in the range is unwritten. Every other command is answered with success on the next cycle.

A small feature-register port sets and gets the error-recovery word. It follows the namespace-ID rules for broadcast and targeted accesses. The block also reports the namespace feature byte, which advertises the unwritten-block error only when a persistent state store is present. It also gives the size of the persisted bitmap image in bytes.

Top module: `blk_alloc_tracker`

## Requirements
- R1: On reset the bitmap is cleared one 32-bit word per clock. `busy` is high and `cmd_ready` is low for exactly NUM_WORDS cycles after reset is released, and every block then reads as unwritten.
- R2: The count fields `cmd_nlb` and `cpl_nlb` are zero-based. A value N covers blocks slba through slba+N inclusive.
- R3: A bit is set only by a completion with `cpl_ok`=1. A write command on the command port, or a completion with `cpl_ok`=0, leaves the bitmap unchanged.
- R4: A read (`cmd_op`=0) is checked only when bit 16 of the error-recovery word is 1. Otherwise it returns status 0x0000 on the cycle after acceptance. Bits 15:0 of the word are stored and read back, and have no effect on checking.
- R5: A checked read returns status 0x0287 if any block in its range is unwritten, and 0x0000 if all blocks in the range are written.
- R6: Write (`cmd_op`=1) and write-zeroes (`cmd_op`=2) commands are never checked. They always return 0x0000 on the cycle after acceptance.
- R7: A checked read scans one word per clock, with `busy` high for the whole scan. It produces a single one-cycle `rsp_valid` pulse. Bits outside the range in the first and last words are masked off.
- R8: Completions accepted during a scan are queued and applied after the scan ends, so a scan's result reflects the bitmap as it stood when the read was accepted.
- R9: Asserting `fmt_req` while the block is idle clears the whole bitmap with the same sweep as reset, and `busy` is high while the sweep runs.
- R10: `ns_features` bit 2 equals `store_present`, and all other bits of `ns_features` are 0.
- R11: A set with namespace ID 0xFFFFFFFF writes the word only when `store_present` is 1. A set aimed at the block's own ID (parameter NSID) always writes the word. A set with any other ID is ignored and returns 0x400B.
- R12: A get with the block's own ID returns the stored word with status 0x0000. Any other ID returns 0x400B (do-not-retry bit 14 set, invalid-namespace code 0x0B). The response appears one cycle after the request.
- R13: `image_bytes` equals ceil(NUM_BLOCKS/8) rounded up to a multiple of 512.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| store_present | input | 1 | A persistent state store is attached |
| fmt_req | input | 1 | Request to clear the whole bitmap |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Command can be accepted this cycle |
| cmd_op | input | 2 | 0 read, 1 write, 2 write-zeroes, 3 treated as unchecked |
| cmd_slba | input | LBA_W | First block of the command |
| cmd_nlb | input | LBA_W | Zero-based block count |
| rsp_valid | output | 1 | One-cycle command response |
| rsp_status | output | 16 | Response status |
| cpl_valid | input | 1 | Write completion present |
| cpl_ready | output | 1 | Completion can be accepted |
| cpl_ok | input | 1 | The write succeeded |
| cpl_slba | input | LBA_W | First block written |
| cpl_nlb | input | LBA_W | Zero-based count written |
| reg_valid | input | 1 | Feature access present |
| reg_write | input | 1 | 1 set, 0 get |
| reg_nsid | input | 32 | Target namespace ID |
| reg_wdata | input | 32 | Word for a set |
| reg_rsp_valid | output | 1 | Feature access response |
| reg_rsp_status | output | 16 | Feature access status |
| reg_rsp_data | output | 32 | Word returned by a get |
| ns_features | output | 8 | Namespace feature byte |
| image_bytes | output | 32 | Persisted bitmap image size |
| busy | output | 1 | Sweep or scan in progress |

## Verification
A corrupted bit in the bitmap appears at the ports only when a checked read covers that block. The bench therefore reads ranges that end exactly on, and one block past, each written span. A lost or misplaced edge mask then flips the status between 0x0000 and 0x0287 in the very next response. A queue or ordering fault in the update path shows up as a read during a scan that sees a completion too early. It can also show up as a later read that never sees it. Both are visible within a scan length, at most NUM_WORDS+1 cycles after the read is accepted. A stuck or mis-timed sweep shows up as `cmd_ready` returning on the wrong cycle, or as blocks that still read as written after a format.

// File: rtl/blk_alloc_pkg.sv
// Shared constants, opcode type and mask helper for the allocation tracker.
// Assumes a 32-bit storage word; all range math is done in block units.
package blk_alloc_pkg;
    localparam int WORD_W = 32;
    localparam int BIT_W  = 5;

    localparam logic [15:0] ST_OK         = 16'h0000;
    localparam logic [15:0] ST_UNWRITTEN  = 16'h0287;
    localparam logic [15:0] ST_BAD_NS     = 16'h400B;
    localparam logic [31:0] NSID_BCAST    = 32'hFFFF_FFFF;

    typedef enum logic [1:0] {
        OP_READ  = 2'd0,
        OP_WRITE = 2'd1,
        OP_WZERO = 2'd2,
        OP_RSVD  = 2'd3
    } op_e;

    // Bits of one word that fall inside a range; lo applies on the first word, hi on the last.
    function automatic logic [WORD_W-1:0] span_mask(input logic [BIT_W-1:0] lo,
                                                    input logic [BIT_W-1:0] hi,
                                                    input logic first,
                                                    input logic last);
        logic [WORD_W-1:0] lo_m;
        logic [WORD_W-1:0] hi_m;
        lo_m = first ? ({WORD_W{1'b1}} << lo) : {WORD_W{1'b1}};
        hi_m = last  ? ({WORD_W{1'b1}} >> (BIT_W'(WORD_W-1) - hi)) : {WORD_W{1'b1}};
        return lo_m & hi_m;
    endfunction
endpackage

// File: rtl/blk_alloc_store.sv
// Bitmap storage with a zeroing sweep.
// Holds NUM_WORDS words with one combinational read port and one write port.
// On reset or sweep_start it writes zero to one word per clock and raises clearing
// until the last word is done. External writes are ignored while clearing.
module blk_alloc_store
    import blk_alloc_pkg::*;
#(
    parameter int NUM_WORDS = 32,
    parameter int IDX_W     = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sweep_start,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [WORD_W-1:0] wr_data,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [WORD_W-1:0] rd_data,
    output logic              clearing
);
    logic [WORD_W-1:0] words [NUM_WORDS];
    logic [IDX_W-1:0]  sweep_ptr;

    // Sweep control: restart on reset or request, stop after the last word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            clearing  <= 1'b1;
            sweep_ptr <= '0;
        end else if (sweep_start) begin
            clearing  <= 1'b1;
            sweep_ptr <= '0;
        end else if (clearing) begin
            sweep_ptr <= sweep_ptr + IDX_W'(1);
            if (sweep_ptr == IDX_W'(NUM_WORDS - 1)) begin
                clearing <= 1'b0;
            end
        end
    end

    // Word array write: the sweep has priority over updates.
    always_ff @(posedge clk) begin
        if (clearing) begin
            words[sweep_ptr] <= '0;
        end else if (wr_en) begin
            words[wr_idx] <= wr_data;
        end
    end

    assign rd_data = words[rd_idx];

    // R1
    // sweep_bounds_chk: the sweep pointer never runs past the last word
    sweep_bounds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clearing |-> (sweep_ptr <= IDX_W'(NUM_WORDS - 1)));
endmodule

// File: rtl/blk_alloc_scan.sv
// Read-range scanner.
// On start it latches the range, then reads one word per clock and tests the
// masked bits for any zero. It stops at the first word with a zero or after
// the last word, and gives a one-cycle done pulse with the hole flag.
// Assumes the range lies inside the namespace and the caller starts it only when idle.
module blk_alloc_scan
    import blk_alloc_pkg::*;
#(
    parameter int LBA_W = 10,
    parameter int IDX_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [LBA_W-1:0]  first_lba,
    input  logic [LBA_W-1:0]  last_lba,
    input  logic [WORD_W-1:0] rd_data,
    output logic [IDX_W-1:0]  rd_idx,
    output logic              active,
    output logic              done,
    output logic              hole
);
    logic [IDX_W-1:0] cur_idx, end_idx;
    logic [BIT_W-1:0] lo_bit, hi_bit;
    logic             on_first;
    logic             on_last;
    logic             miss;

    assign on_last = (cur_idx == end_idx);
    assign miss    = |(~rd_data & span_mask(lo_bit, hi_bit, on_first, on_last));
    assign rd_idx  = cur_idx;

    // Scan walker: latch the range, step one word per clock, stop early on a hole.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active   <= 1'b0;
            done     <= 1'b0;
            hole     <= 1'b0;
            cur_idx  <= '0;
            end_idx  <= '0;
            lo_bit   <= '0;
            hi_bit   <= '0;
            on_first <= 1'b0;
        end else begin
            done <= 1'b0;
            if (start) begin
                active   <= 1'b1;
                cur_idx  <= first_lba[LBA_W-1:BIT_W];
                end_idx  <= last_lba[LBA_W-1:BIT_W];
                lo_bit   <= first_lba[BIT_W-1:0];
                hi_bit   <= last_lba[BIT_W-1:0];
                on_first <= 1'b1;
            end else if (active) begin
                on_first <= 1'b0;
                if (miss || on_last) begin
                    active <= 1'b0;
                    done   <= 1'b1;
                    hole   <= miss;
                end else begin
                    cur_idx <= cur_idx + IDX_W'(1);
                end
            end
        end
    end

    // R7
    // scan_start_idle_chk: a new scan never begins on top of a running one
    scan_start_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> !active);

    // R7
    // scan_done_pulse_chk: done lasts one cycle and follows an active cycle
    scan_done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($past(active) && !$past(done)));
endmodule

// File: rtl/blk_alloc_setq.sv
// Completion queue and bitmap setter.
// Successful write ranges are pushed into a small FIFO. When not held, the head
// range is popped and its words are OR-ed with the range mask, one word per clock.
// Assumes QDEPTH is a power of two and the pusher respects full.
module blk_alloc_setq
    import blk_alloc_pkg::*;
#(
    parameter int LBA_W  = 10,
    parameter int IDX_W  = 5,
    parameter int QDEPTH = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic [LBA_W-1:0]  push_first,
    input  logic [LBA_W-1:0]  push_last,
    input  logic              hold,
    input  logic [WORD_W-1:0] rd_data,
    output logic [IDX_W-1:0]  rd_idx,
    output logic              wr_en,
    output logic [IDX_W-1:0]  wr_idx,
    output logic [WORD_W-1:0] wr_data,
    output logic              full,
    output logic              idle
);
    localparam int PTR_W = (QDEPTH > 1) ? $clog2(QDEPTH) : 1;
    localparam int CNT_W = PTR_W + 1;

    logic [LBA_W-1:0] q_first [QDEPTH];
    logic [LBA_W-1:0] q_last  [QDEPTH];
    logic [PTR_W-1:0] wptr, rptr;
    logic [CNT_W-1:0] cnt;
    logic             pop;
    logic             running;
    logic [IDX_W-1:0] cur_idx, end_idx;
    logic [BIT_W-1:0] lo_bit, hi_bit;
    logic             on_first;
    logic             on_last;

    assign full    = (cnt == CNT_W'(QDEPTH));
    assign pop     = !hold && !running && (cnt != '0);
    assign idle    = !running && (cnt == '0);
    assign on_last = (cur_idx == end_idx);
    assign rd_idx  = cur_idx;
    assign wr_idx  = cur_idx;
    assign wr_en   = running && !hold;
    assign wr_data = rd_data | span_mask(lo_bit, hi_bit, on_first, on_last);

    // FIFO pointers and occupancy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wptr <= '0;
            rptr <= '0;
            cnt  <= '0;
        end else begin
            if (push) wptr <= wptr + PTR_W'(1);
            if (pop)  rptr <= rptr + PTR_W'(1);
            case ({push, pop})
                2'b10:   cnt <= cnt + CNT_W'(1);
                2'b01:   cnt <= cnt - CNT_W'(1);
                default: cnt <= cnt;
            endcase
        end
    end

    // FIFO entry storage.
    always_ff @(posedge clk) begin
        if (push) begin
            q_first[wptr] <= push_first;
            q_last[wptr]  <= push_last;
        end
    end

    // Setter walker: take the head range and mark its words one per clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            running  <= 1'b0;
            cur_idx  <= '0;
            end_idx  <= '0;
            lo_bit   <= '0;
            hi_bit   <= '0;
            on_first <= 1'b0;
        end else if (pop) begin
            running  <= 1'b1;
            cur_idx  <= q_first[rptr][LBA_W-1:BIT_W];
            end_idx  <= q_last[rptr][LBA_W-1:BIT_W];
            lo_bit   <= q_first[rptr][BIT_W-1:0];
            hi_bit   <= q_last[rptr][BIT_W-1:0];
            on_first <= 1'b1;
        end else if (running && !hold) begin
            on_first <= 1'b0;
            if (on_last) begin
                running <= 1'b0;
            end else begin
                cur_idx <= cur_idx + IDX_W'(1);
            end
        end
    end

    // R8
    // fifo_no_overflow_chk: never push into a full queue
    fifo_no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !full);
endmodule

// File: rtl/blk_alloc_feat.sv
// Per-namespace feature registers.
// Holds the error-recovery word and answers set/get accesses one cycle later.
// A broadcast set lands only when the store is present. A targeted set to the own
// ID always lands, and any other ID is rejected with the do-not-retry status.
module blk_alloc_feat
    import blk_alloc_pkg::*;
#(
    parameter logic [31:0] NSID = 32'd1
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req_valid,
    input  logic        req_write,
    input  logic [31:0] req_nsid,
    input  logic [31:0] req_wdata,
    input  logic        store_present,
    output logic        rsp_valid,
    output logic [15:0] rsp_status,
    output logic [31:0] rsp_data,
    output logic        check_en,
    output logic [7:0]  features
);
    logic [31:0] err_rec;

    assign check_en = err_rec[16];
    assign features = {5'b0, store_present, 2'b00};

    // Access decode: update the word and form the registered response.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_rec    <= '0;
            rsp_valid  <= 1'b0;
            rsp_status <= ST_OK;
            rsp_data   <= '0;
        end else begin
            rsp_valid <= req_valid;
            if (req_valid) begin
                rsp_data   <= '0;
                rsp_status <= ST_OK;
                if (req_write) begin
                    if (req_nsid == NSID_BCAST) begin
                        if (store_present) err_rec <= req_wdata;
                    end else if (req_nsid == NSID) begin
                        err_rec <= req_wdata;
                    end else begin
                        rsp_status <= ST_BAD_NS;
                    end
                end else if (req_nsid == NSID) begin
                    rsp_data <= err_rec;
                end else begin
                    rsp_status <= ST_BAD_NS;
                end
            end
        end
    end

    // R12
    // reg_rsp_follow_chk: every response answers a request from the previous cycle
    reg_rsp_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $past(req_valid));
endmodule

// File: rtl/blk_alloc_tracker.sv
// Logical block allocation tracker, top level.
// Accepts commands and write completions, keeps the allocation bitmap, and answers
// checked reads with an unwritten-block status. Commands are accepted only when no
// sweep, scan or pending update is in flight. Range bounds are the caller's job.
module blk_alloc_tracker
    import blk_alloc_pkg::*;
#(
    parameter int          NUM_BLOCKS = 1024,
    parameter int          QDEPTH     = 4,
    parameter logic [31:0] NSID       = 32'd1,
    parameter int          LBA_W      = $clog2(NUM_BLOCKS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             store_present,
    input  logic             fmt_req,
    input  logic             cmd_valid,
    output logic             cmd_ready,
    input  logic [1:0]       cmd_op,
    input  logic [LBA_W-1:0] cmd_slba,
    input  logic [LBA_W-1:0] cmd_nlb,
    output logic             rsp_valid,
    output logic [15:0]      rsp_status,
    input  logic             cpl_valid,
    output logic             cpl_ready,
    input  logic             cpl_ok,
    input  logic [LBA_W-1:0] cpl_slba,
    input  logic [LBA_W-1:0] cpl_nlb,
    input  logic             reg_valid,
    input  logic             reg_write,
    input  logic [31:0]      reg_nsid,
    input  logic [31:0]      reg_wdata,
    output logic             reg_rsp_valid,
    output logic [15:0]      reg_rsp_status,
    output logic [31:0]      reg_rsp_data,
    output logic [7:0]       ns_features,
    output logic [31:0]      image_bytes,
    output logic             busy
);
    localparam int NUM_WORDS = (NUM_BLOCKS + WORD_W - 1) / WORD_W;
    localparam int IDX_W     = LBA_W - BIT_W;
    localparam int MAP_BYTES = (NUM_BLOCKS + 7) / 8;
    localparam int IMG_BYTES = ((MAP_BYTES + 511) / 512) * 512;

    logic              clearing;
    logic              scan_active, scan_done, scan_hole;
    logic              set_full, set_idle;
    logic              set_wr_en;
    logic [IDX_W-1:0]  set_wr_idx, set_rd_idx, scan_rd_idx, mem_rd_idx;
    logic [WORD_W-1:0] set_wr_data, mem_rd_data;
    logic              check_en;
    logic              idle_core;
    logic              accept, scan_start, quick, quick_q;
    logic              cpl_push, fmt_start;

    assign idle_core  = !clearing && !scan_active && set_idle;
    assign cmd_ready  = idle_core && !fmt_req;
    assign fmt_start  = fmt_req && idle_core;
    assign accept     = cmd_valid && cmd_ready;
    assign scan_start = accept && (op_e'(cmd_op) == OP_READ) && check_en;
    assign quick      = accept && !scan_start;
    assign cpl_ready  = !clearing && !set_full;
    assign cpl_push   = cpl_valid && cpl_ready && cpl_ok;
    assign mem_rd_idx = scan_active ? scan_rd_idx : set_rd_idx;
    assign busy       = clearing || scan_active;
    assign image_bytes = 32'(IMG_BYTES);
    assign rsp_valid  = quick_q || scan_done;
    assign rsp_status = (scan_done && scan_hole) ? ST_UNWRITTEN : ST_OK;

    // Unchecked commands answer one cycle after acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) quick_q <= 1'b0;
        else        quick_q <= quick;
    end

    blk_alloc_store #(.NUM_WORDS(NUM_WORDS), .IDX_W(IDX_W)) u_store (
        .clk         (clk),
        .rst_n       (rst_n),
        .sweep_start (fmt_start),
        .wr_en       (set_wr_en),
        .wr_idx      (set_wr_idx),
        .wr_data     (set_wr_data),
        .rd_idx      (mem_rd_idx),
        .rd_data     (mem_rd_data),
        .clearing    (clearing)
    );

    blk_alloc_scan #(.LBA_W(LBA_W), .IDX_W(IDX_W)) u_scan (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (scan_start),
        .first_lba (cmd_slba),
        .last_lba  (cmd_slba + cmd_nlb),
        .rd_data   (mem_rd_data),
        .rd_idx    (scan_rd_idx),
        .active    (scan_active),
        .done      (scan_done),
        .hole      (scan_hole)
    );

    blk_alloc_setq #(.LBA_W(LBA_W), .IDX_W(IDX_W), .QDEPTH(QDEPTH)) u_setq (
        .clk        (clk),
        .rst_n      (rst_n),
        .push       (cpl_push),
        .push_first (cpl_slba),
        .push_last  (cpl_slba + cpl_nlb),
        .hold       (scan_active || clearing),
        .rd_data    (mem_rd_data),
        .rd_idx     (set_rd_idx),
        .wr_en      (set_wr_en),
        .wr_idx     (set_wr_idx),
        .wr_data    (set_wr_data),
        .full       (set_full),
        .idle       (set_idle)
    );

    blk_alloc_feat #(.NSID(NSID)) u_feat (
        .clk           (clk),
        .rst_n         (rst_n),
        .req_valid     (reg_valid),
        .req_write     (reg_write),
        .req_nsid      (reg_nsid),
        .req_wdata     (reg_wdata),
        .store_present (store_present),
        .rsp_valid     (reg_rsp_valid),
        .rsp_status    (reg_rsp_status),
        .rsp_data      (reg_rsp_data),
        .check_en      (check_en),
        .features      (ns_features)
    );

    // R7
    // rsp_single_source_chk: the quick path and the scan never answer together
    rsp_single_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({quick_q, scan_done}));

    // R8
    // no_set_during_scan_chk: bitmap updates wait for the scan to finish
    no_set_during_scan_chk: assert property (@(posedge clk) disable iff (!rst_n)
        set_wr_en |-> !scan_active);

    // R1
    // no_cmd_in_sweep_chk: no command is taken while the bitmap is being cleared
    no_cmd_in_sweep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        accept |-> !clearing);

    // R5
    // rsp_status_legal_chk: a response carries only success or the unwritten code
    rsp_status_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (rsp_status == ST_OK || rsp_status == ST_UNWRITTEN));
endmodule

// File: tb/blk_alloc_tracker_test.sv
module blk_alloc_tracker_test;
    localparam int NB    = 1024;
    localparam int LW    = 10;
    localparam int NW    = 32;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic store_present = 1'b1;
    logic fmt_req = 1'b0;
    logic cmd_valid = 1'b0;
    logic cmd_ready;
    logic [1:0] cmd_op = 2'd0;
    logic [LW-1:0] cmd_slba = '0, cmd_nlb = '0;
    logic rsp_valid;
    logic [15:0] rsp_status;
    logic cpl_valid = 1'b0, cpl_ready, cpl_ok = 1'b0;
    logic [LW-1:0] cpl_slba = '0, cpl_nlb = '0;
    logic reg_valid = 1'b0, reg_write = 1'b0;
    logic [31:0] reg_nsid = '0, reg_wdata = '0;
    logic reg_rsp_valid;
    logic [15:0] reg_rsp_status;
    logic [31:0] reg_rsp_data;
    logic [7:0] ns_features;
    logic [31:0] image_bytes;
    logic busy;

    int checks = 0;
    int failures = 0;
    bit model [NB];
    bit chk_on = 1'b0;
    logic [15:0] exp_q [$];
    string tag_q [$];

    always #10 clk = ~clk;

    blk_alloc_tracker #(.NUM_BLOCKS(NB)) uut (
        .clk(clk), .rst_n(rst_n), .store_present(store_present), .fmt_req(fmt_req),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op),
        .cmd_slba(cmd_slba), .cmd_nlb(cmd_nlb), .rsp_valid(rsp_valid),
        .rsp_status(rsp_status), .cpl_valid(cpl_valid), .cpl_ready(cpl_ready),
        .cpl_ok(cpl_ok), .cpl_slba(cpl_slba), .cpl_nlb(cpl_nlb),
        .reg_valid(reg_valid), .reg_write(reg_write), .reg_nsid(reg_nsid),
        .reg_wdata(reg_wdata), .reg_rsp_valid(reg_rsp_valid),
        .reg_rsp_status(reg_rsp_status), .reg_rsp_data(reg_rsp_data),
        .ns_features(ns_features), .image_bytes(image_bytes), .busy(busy)
    );

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] exp_read(input int s, input int n);
        if (!chk_on) return 16'h0000;
        for (int i = s; i <= s + n; i++) begin
            if (!model[i]) return 16'h0287;
        end
        return 16'h0000;
    endfunction

    // Scoreboard monitor: every response is compared against the oldest expectation.
    always @(negedge clk) begin
        if (rst_n && rsp_valid) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R7 unexpected response", 32'(rsp_status), 32'hFFFF);
            end else begin
                logic [15:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check(rsp_status == e, t, 32'(rsp_status), 32'(e));
            end
        end
    end

    // Driver: issue one command and push its expected status.
    task automatic send_cmd(input logic [1:0] op, input int s, input int n, input string tag);
        @(negedge clk);
        while (!cmd_ready) @(negedge clk);
        cmd_valid = 1'b1; cmd_op = op; cmd_slba = LW'(s); cmd_nlb = LW'(n);
        exp_q.push_back((op == 2'd0) ? exp_read(s, n) : 16'h0000);
        tag_q.push_back(tag);
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic send_cpl(input int s, input int n, input bit ok);
        @(negedge clk);
        while (!cpl_ready) @(negedge clk);
        cpl_valid = 1'b1; cpl_ok = ok; cpl_slba = LW'(s); cpl_nlb = LW'(n);
        @(negedge clk);
        cpl_valid = 1'b0;
        if (ok) for (int i = s; i <= s + n; i++) model[i] = 1'b1;
    endtask

    task automatic reg_op(input bit wr, input logic [31:0] ns, input logic [31:0] wd,
                          output logic [15:0] st, output logic [31:0] rd);
        @(negedge clk);
        reg_valid = 1'b1; reg_write = wr; reg_nsid = ns; reg_wdata = wd;
        @(negedge clk);
        reg_valid = 1'b0;
        check(reg_rsp_valid == 1'b1, "R12 response one cycle later", 32'(reg_rsp_valid), 32'd1);
        st = reg_rsp_status;
        rd = reg_rsp_data;
    endtask

    task automatic drain();
        int guard = 0;
        while (exp_q.size() != 0 && guard < 200) begin @(negedge clk); guard++; end
        @(negedge clk);
        while (!cmd_ready) @(negedge clk);
    endtask

    initial begin
        repeat (300000) @(posedge clk);
        checks++; failures++;
        $display("FAIL R1 watchdog actual=hung expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [15:0] st;
        logic [31:0] rd;
        int n;
        for (int i = 0; i < NB; i++) model[i] = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: sweep length and busy after reset
        check(!cmd_ready && busy, "R1 busy at reset release", {30'd0, cmd_ready, busy}, 32'd1);
        n = 0;
        while (!cmd_ready) begin @(negedge clk); n++; end
        check(n == NW, "R1 sweep cycles", 32'(n), 32'(NW));
        check(ns_features == 8'h04, "R10 features with store", 32'(ns_features), 32'h04);
        check(image_bytes == 32'd512, "R13 image size", image_bytes, 32'd512);

        // R12: reset word and invalid id
        reg_op(1'b0, 32'd1, 32'd0, st, rd);
        check(st == 16'h0 && rd == 32'h0, "R12 get own id after reset", rd, 32'h0);
        reg_op(1'b0, 32'd5, 32'd0, st, rd);
        check(st == 16'h400B, "R12 get invalid id", 32'(st), 32'h400B);

        // R4: disabled check gives success on unwritten blocks
        send_cmd(2'd0, 0, 0, "R4 read unchecked");
        drain();

        // R11/R4: targeted set, low half stored
        reg_op(1'b1, 32'd1, 32'h0001_1234, st, rd);
        check(st == 16'h0, "R11 targeted set status", 32'(st), 32'h0);
        reg_op(1'b0, 32'd1, 32'd0, st, rd);
        check(rd == 32'h0001_1234, "R4 word readback", rd, 32'h0001_1234);
        chk_on = 1'b1;

        send_cmd(2'd0, 0, 0, "R1 cleared block unwritten");
        send_cmd(2'd1, 10, 2, "R6 write command success");
        send_cmd(2'd0, 10, 2, "R3 write command sets nothing");
        drain();
        send_cpl(10, 2, 1'b0);
        drain();
        send_cmd(2'd0, 10, 2, "R3 failed completion sets nothing");
        send_cpl(10, 2, 1'b1);
        drain();
        send_cmd(2'd0, 10, 2, "R5 written range success");
        send_cmd(2'd0, 10, 3, "R2 one past range");
        send_cmd(2'd0, 9, 3, "R2 one before range");
        send_cmd(2'd0, 12, 0, "R2 last block inclusive");
        send_cpl(30, 35, 1'b1);
        drain();
        send_cmd(2'd0, 30, 35, "R7 cross-word range");
        send_cmd(2'd0, 29, 36, "R7 first-word mask");
        send_cmd(2'd0, 31, 35, "R7 last-word mask");
        send_cmd(2'd2, 500, 7, "R6 write-zeroes success");
        drain();

        // R8: completion during a scan is deferred
        send_cpl(0, 639, 1'b1);
        send_cpl(641, 382, 1'b1);
        drain();
        fork
            send_cmd(2'd0, 0, 1023, "R8 scan sees snapshot");
            begin
                repeat (4) @(negedge clk);
                check(busy == 1'b1, "R7 busy during scan", 32'(busy), 32'd1);
                send_cpl(640, 0, 1'b1);
            end
        join
        drain();
        send_cmd(2'd0, 0, 1023, "R8 deferred update applied");
        drain();

        // R4: clearing the enable turns the check off
        reg_op(1'b1, 32'd1, 32'h0000_0000, st, rd);
        chk_on = 1'b0;
        send_cmd(2'd0, 900, 0, "R4 check disabled");
        drain();

        // R10/R11: broadcast depends on store presence
        reg_op(1'b1, 32'd1, 32'h0001_0000, st, rd);
        chk_on = 1'b1;
        store_present = 1'b0;
        @(negedge clk);
        check(ns_features == 8'h00, "R10 features without store", 32'(ns_features), 32'h0);
        reg_op(1'b1, 32'hFFFF_FFFF, 32'h0, st, rd);
        reg_op(1'b0, 32'd1, 32'd0, st, rd);
        check(rd == 32'h0001_0000, "R11 broadcast ignored without store", rd, 32'h0001_0000);
        store_present = 1'b1;
        reg_op(1'b1, 32'hFFFF_FFFF, 32'h0001_0005, st, rd);
        reg_op(1'b0, 32'd1, 32'd0, st, rd);
        check(rd == 32'h0001_0005, "R11 broadcast with store", rd, 32'h0001_0005);
        reg_op(1'b1, 32'd3, 32'h0, st, rd);
        check(st == 16'h400B, "R11 other id rejected", 32'(st), 32'h400B);
        reg_op(1'b0, 32'd1, 32'd0, st, rd);
        check(rd == 32'h0001_0005, "R11 other id leaves word", rd, 32'h0001_0005);

        // R9: format clears the bitmap
        @(negedge clk);
        fmt_req = 1'b1;
        @(negedge clk);
        fmt_req = 1'b0;
        check(busy == 1'b1, "R9 busy during format", 32'(busy), 32'd1);
        for (int i = 0; i < NB; i++) model[i] = 1'b0;
        while (!cmd_ready) @(negedge clk);
        send_cmd(2'd0, 10, 2, "R9 range unwritten after format");
        send_cmd(2'd0, 640, 0, "R9 single block after format");
        drain();

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule